// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a parallel flash bus and the rest of a NOR-style flash device. It watches bus write cycles and turns them into commands. Single-write commands take effect at once. Program and erase sequences need several writes, so the block gathers those writes, checks them, and then starts a job on a program/erase engine over a one-cycle start pulse. The engine reports back through `eng_busy`, `eng_done` and `eng_err`. The block also handles suspend and resume of a running job, and it limits which commands are accepted while a job is running or suspended.

Every bus read returns one of three sources, picked by the current read mode: the memory array, the status register, or a two-byte signature. A program or erase command switches reads to the status register. Reads stay there until a new read-mode command is written. The status register has the following bits:

| Bit | Meaning |
|-----|---------|
| 7 | Ready |
| 6 | Erase suspended |
| 5 | Erase error |
| 4 | Program error |
| 3 | Sequence error |
| 2 | Program suspended |
| 1:0 | Always 0 |

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, the read mode is array and no job, suspend or resume pulse is issued. The status register reads 80h while `eng_busy` is 0.
- R2: Mode-select opcodes work as follows, and each mode holds until a new mode-select is written:
  - FFh selects array reads.
  - 70h selects status reads.
  - 90h and 98h select signature reads: `MFG_ID` when `rd_addr[0]`=0 and `DEV_ID` when it is 1.
  - `rd_data` and `rd_valid` appear one cycle after `rd_en`.
- R3: A write of 40h or 10h followed by one address/data write starts a job. `job_start` pulses one cycle after the second write, with `job_op`=1, that address, and the data in `job_data[7:0]`. Reads then return status.
- R4: 30h followed by four writes starts `job_op`=2. The four addresses must share all bits above bit 1, and their low bits must be 0, 1, 2 and 3 in that order. Byte k goes to `job_data[8k+7:8k]`, and `job_addr` is the first address.
- R5: A quad-program address that breaks the rule in R4 ends the sequence at that write. It sets status bits 4 and 3, starts no job, and leaves reads in status mode.
- R6: Each erase takes a command write and then a confirm write:
  - 80h then 10h starts a chip erase, `job_op`=3.
  - 20h then D0h starts a block erase, `job_op`=4.
  - 32h then D0h starts a sector erase, `job_op`=5.
  - `job_addr` is the confirm write's address.
- R7: A wrong erase confirm code sets status bits 5 and 3, starts no job, and leaves reads in status mode.
- R8: 50h written while idle clears status bits 5, 4 and 3.
- R9: Status bit 7 reads as the inverse of `eng_busy`. When `eng_done` arrives with `eng_err`, the block sets bit 5 for an erase job or bit 4 for a program job.
- R10: Suspend and resume work as follows:
  - B0h written while a job runs pulses `susp_req` and sets bit 6 (erase) or bit 2 (program).
  - D0h written while suspended pulses `resume_req` and clears that bit.
  - At most one of `job_start`, `susp_req` and `resume_req` is high in any cycle.
- R11: While a job is suspended, only FFh, 70h, D0h and program commands (40h, 10h, 30h) are accepted. Program commands are accepted only during an erase suspend. All other writes are ignored.
- R12: Reserved or undefined opcodes, such as 00h, 01h, 60h, 2Fh and C0h, change neither the read mode nor the status.
- R13: While a job runs and is not suspended, only 70h and B0h are acted on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data / opcode |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Read address |
| array_q | input | 8 | Array data for `rd_addr` |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 8 | Read data |
| eng_busy | input | 1 | Engine is working |
| eng_done | input | 1 | Engine finished a job (pulse) |
| eng_err | input | 1 | Job failed, qualified by `eng_done` |
| job_start | output | 1 | Start pulse to the engine |
| job_op | output | 3 | Job kind |
| job_addr | output | ADDR_W | Job address |
| job_data | output | 32 | Program data |
| susp_req | output | 1 | Suspend request pulse |
| resume_req | output | 1 | Resume request pulse |

## Verification
Writes and reads are each sampled on one rising edge. `job_start`, `susp_req` and `resume_req` pulse in the cycle right after the write that completes a command. `rd_data` carries the source chosen by the mode that was in force at the sampling edge. Status bit 7 follows whatever `eng_busy` was at that edge. Stimulus changes on falling edges and every result is checked on the next falling edge. A behavioural model steps on each rising edge, and its expected pulses and read data are compared with the design's outputs on every cycle. Direct checks against hand-worked values at the same half-cycle cover each requirement.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_SIG    = 2'd2
  } rd_mode_e;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_QUAD   = 3'd2,
    OP_CHIP   = 3'd3,
    OP_BLOCK  = 3'd4,
    OP_SECTOR = 3'd5
  } job_op_e;

  typedef enum logic [3:0] {
    C_NONE, C_ARRAY, C_STATUS, C_SIG, C_PROG, C_QUAD,
    C_CHIP, C_BLOCK, C_SECTOR, C_CLEAR, C_SUSP, C_RESUME
  } cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PROG, SQ_QUAD, SQ_CHIP, SQ_BLOCK, SQ_SECTOR
  } seq_e;

  localparam logic [7:0] OPC_ARRAY   = 8'hFF;
  localparam logic [7:0] OPC_STATUS  = 8'h70;
  localparam logic [7:0] OPC_SIG_A   = 8'h90;
  localparam logic [7:0] OPC_SIG_B   = 8'h98;
  localparam logic [7:0] OPC_PROG_A  = 8'h40;
  localparam logic [7:0] OPC_PROG_B  = 8'h10;
  localparam logic [7:0] OPC_QUAD    = 8'h30;
  localparam logic [7:0] OPC_CHIP    = 8'h80;
  localparam logic [7:0] OPC_CHIP_OK = 8'h10;
  localparam logic [7:0] OPC_BLOCK   = 8'h20;
  localparam logic [7:0] OPC_SECTOR  = 8'h32;
  localparam logic [7:0] OPC_CONFIRM = 8'hD0;
  localparam logic [7:0] OPC_CLEAR   = 8'h50;
  localparam logic [7:0] OPC_SUSP    = 8'hB0;

  localparam int SR_READY  = 7;
  localparam int SR_ESUSP  = 6;
  localparam int SR_EERR   = 5;
  localparam int SR_PERR   = 4;
  localparam int SR_SEQERR = 3;
  localparam int SR_PSUSP  = 2;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [7:0] opcode,
  output cmd_e       cmd
);

  always_comb begin
    unique case (opcode)
      OPC_ARRAY:             cmd = C_ARRAY;
      OPC_STATUS:            cmd = C_STATUS;
      OPC_SIG_A, OPC_SIG_B:  cmd = C_SIG;
      OPC_PROG_A, OPC_PROG_B: cmd = C_PROG;
      OPC_QUAD:              cmd = C_QUAD;
      OPC_CHIP:              cmd = C_CHIP;
      OPC_BLOCK:             cmd = C_BLOCK;
      OPC_SECTOR:            cmd = C_SECTOR;
      OPC_CLEAR:             cmd = C_CLEAR;
      OPC_SUSP:              cmd = C_SUSP;
      OPC_CONFIRM:           cmd = C_RESUME;
      default:               cmd = C_NONE;
    endcase
  end

endmodule

// File: rtl/flash_status_bits.sv
module flash_status_bits
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eng_busy,
  input  logic       set_seq,
  input  logic       set_prog,
  input  logic       set_erase,
  input  logic       clr_err,
  input  logic       susp_erase,
  input  logic       susp_prog,
  output logic [7:0] sr
);

  logic e_erase_q, e_prog_q, e_seq_q;
  logic e_erase_d, e_prog_d, e_seq_d;

  // set takes priority over clear in the same cycle
  always_comb begin
    e_erase_d = (e_erase_q & ~clr_err) | set_erase;
    e_prog_d  = (e_prog_q  & ~clr_err) | set_prog;
    e_seq_d   = (e_seq_q   & ~clr_err) | set_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_erase_q <= 1'b0;
      e_prog_q  <= 1'b0;
      e_seq_q   <= 1'b0;
    end else begin
      e_erase_q <= e_erase_d;
      e_prog_q  <= e_prog_d;
      e_seq_q   <= e_seq_d;
    end
  end

  always_comb begin
    sr            = '0;
    sr[SR_READY]  = ~eng_busy;
    sr[SR_ESUSP]  = susp_erase;
    sr[SR_EERR]   = e_erase_q;
    sr[SR_PERR]   = e_prog_q;
    sr[SR_SEQERR] = e_seq_q;
    sr[SR_PSUSP]  = susp_prog;
  end

endmodule

// File: rtl/flash_read_path.sv
module flash_read_path
  import flash_cmd_pkg::*;
#(
  parameter logic [7:0] MFG_ID = 8'h20,
  parameter logic [7:0] DEV_ID = 8'hE5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       sig_sel,
  input  rd_mode_e   mode,
  input  logic [7:0] array_q,
  input  logic [7:0] sr,
  output logic       rd_valid,
  output logic [7:0] rd_data
);

  logic [7:0] pick;

  always_comb begin
    unique case (mode)
      RM_STATUS: pick = sr;
      RM_SIG:    pick = sig_sel ? DEV_ID : MFG_ID;
      default:   pick = array_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= pick;
    end
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W = 20,
  parameter logic [7:0] MFG_ID = 8'h20,
  parameter logic [7:0] DEV_ID = 8'hE5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        array_q,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  input  logic              eng_busy,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic              job_start,
  output logic [2:0]        job_op,
  output logic [ADDR_W-1:0] job_addr,
  output logic [31:0]       job_data,
  output logic              susp_req,
  output logic              resume_req
);

  localparam int QUAD_N  = 4;
  localparam int QIDX_W  = $clog2(QUAD_N);
  localparam int QDATA_W = QUAD_N * 8;

  cmd_e     cmd;
  seq_e     seq_q, seq_d;
  rd_mode_e mode_q, mode_d;
  logic [QIDX_W-1:0]  qidx_q, qidx_d;
  logic [ADDR_W-1:0]  qbase_q, qbase_d;
  logic [QDATA_W-1:0] qdata_q, qdata_d;
  logic act_q, act_d;
  logic cur_er_q, cur_er_d;
  logic sus_er_q, sus_er_d;
  logic sus_pg_q, sus_pg_d;
  logic              start_d, sreq_d, rreq_d;
  logic [2:0]        op_d;
  logic [ADDR_W-1:0] jaddr_d;
  logic [31:0]       jdata_d;
  logic set_seq, set_prog, set_erase, clr_err;
  logic suspended, quad_ok;
  logic [7:0] sr_w;

  flash_cmd_decode i_dec (.opcode(wr_data), .cmd(cmd));

  assign suspended = sus_er_q | sus_pg_q;
  assign quad_ok   = (qidx_q == '0) ? (wr_addr[QIDX_W-1:0] == '0)
                   : ((wr_addr[ADDR_W-1:QIDX_W] == qbase_q[ADDR_W-1:QIDX_W]) &&
                      (wr_addr[QIDX_W-1:0] == qidx_q));

  always_comb begin
    seq_d    = seq_q;
    mode_d   = mode_q;
    qidx_d   = qidx_q;
    qbase_d  = qbase_q;
    qdata_d  = qdata_q;
    act_d    = act_q;
    cur_er_d = cur_er_q;
    sus_er_d = sus_er_q;
    sus_pg_d = sus_pg_q;
    start_d  = 1'b0;
    sreq_d   = 1'b0;
    rreq_d   = 1'b0;
    op_d     = job_op;
    jaddr_d  = job_addr;
    jdata_d  = job_data;
    set_seq  = 1'b0;
    set_prog = 1'b0;
    set_erase = 1'b0;
    clr_err  = 1'b0;

    if (eng_done) begin
      act_d = 1'b0;
      if (eng_err) begin
        if (cur_er_q) set_erase = 1'b1;
        else          set_prog  = 1'b1;
      end
    end

    if (wr_en) begin
      if (seq_q != SQ_IDLE) begin
        seq_d = SQ_IDLE;
        unique case (seq_q)
          SQ_PROG: begin
            start_d = 1'b1; op_d = OP_PROG; jaddr_d = wr_addr;
            jdata_d = {24'h0, wr_data}; cur_er_d = 1'b0;
          end
          SQ_QUAD: begin
            if (!quad_ok) begin
              set_seq = 1'b1; set_prog = 1'b1; mode_d = RM_STATUS;
            end else begin
              if (qidx_q == '0) qbase_d = wr_addr;
              qdata_d[qidx_q*8 +: 8] = wr_data;
              qidx_d = qidx_q + 1'b1;
              if (qidx_q == QIDX_W'(QUAD_N-1)) begin
                start_d = 1'b1; op_d = OP_QUAD; jaddr_d = qbase_q;
                jdata_d = qdata_d; cur_er_d = 1'b0;
              end else begin
                seq_d = SQ_QUAD;
              end
            end
          end
          SQ_CHIP: begin
            if (wr_data == OPC_CHIP_OK) begin
              start_d = 1'b1; op_d = OP_CHIP; jaddr_d = wr_addr;
              jdata_d = '0; cur_er_d = 1'b1;
            end else begin
              set_seq = 1'b1; set_erase = 1'b1; mode_d = RM_STATUS;
            end
          end
          default: begin
            if (wr_data == OPC_CONFIRM) begin
              start_d = 1'b1; jaddr_d = wr_addr; jdata_d = '0; cur_er_d = 1'b1;
              op_d = (seq_q == SQ_BLOCK) ? OP_BLOCK : OP_SECTOR;
            end else begin
              set_seq = 1'b1; set_erase = 1'b1; mode_d = RM_STATUS;
            end
          end
        endcase
        if (start_d) act_d = 1'b1;
      end else if (act_q) begin
        if (cmd == C_STATUS) mode_d = RM_STATUS;
        else if (cmd == C_SUSP && !suspended) begin
          sreq_d   = 1'b1;
          act_d    = 1'b0;
          sus_er_d = cur_er_q;
          sus_pg_d = ~cur_er_q;
        end
      end else if (suspended) begin
        unique case (cmd)
          C_ARRAY:  mode_d = RM_ARRAY;
          C_STATUS: mode_d = RM_STATUS;
          C_RESUME: begin
            rreq_d = 1'b1; act_d = 1'b1; cur_er_d = sus_er_q;
            sus_er_d = 1'b0; sus_pg_d = 1'b0; mode_d = RM_STATUS;
          end
          C_PROG: if (sus_er_q) begin seq_d = SQ_PROG; mode_d = RM_STATUS; end
          C_QUAD: if (sus_er_q) begin seq_d = SQ_QUAD; qidx_d = '0; mode_d = RM_STATUS; end
          default: ;
        endcase
      end else begin
        unique case (cmd)
          C_ARRAY:  mode_d = RM_ARRAY;
          C_STATUS: mode_d = RM_STATUS;
          C_SIG:    mode_d = RM_SIG;
          C_PROG:   begin seq_d = SQ_PROG;   mode_d = RM_STATUS; end
          C_QUAD:   begin seq_d = SQ_QUAD;   qidx_d = '0; mode_d = RM_STATUS; end
          C_CHIP:   begin seq_d = SQ_CHIP;   mode_d = RM_STATUS; end
          C_BLOCK:  begin seq_d = SQ_BLOCK;  mode_d = RM_STATUS; end
          C_SECTOR: begin seq_d = SQ_SECTOR; mode_d = RM_STATUS; end
          C_CLEAR:  clr_err = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q      <= SQ_IDLE;
      mode_q     <= RM_ARRAY;
      qidx_q     <= '0;
      qbase_q    <= '0;
      qdata_q    <= '0;
      act_q      <= 1'b0;
      cur_er_q   <= 1'b0;
      sus_er_q   <= 1'b0;
      sus_pg_q   <= 1'b0;
      job_start  <= 1'b0;
      job_op     <= OP_NONE;
      job_addr   <= '0;
      job_data   <= '0;
      susp_req   <= 1'b0;
      resume_req <= 1'b0;
    end else begin
      seq_q      <= seq_d;
      mode_q     <= mode_d;
      qidx_q     <= qidx_d;
      qbase_q    <= qbase_d;
      qdata_q    <= qdata_d;
      act_q      <= act_d;
      cur_er_q   <= cur_er_d;
      sus_er_q   <= sus_er_d;
      sus_pg_q   <= sus_pg_d;
      job_start  <= start_d;
      susp_req   <= sreq_d;
      resume_req <= rreq_d;
      if (start_d) begin
        job_op   <= op_d;
        job_addr <= jaddr_d;
        job_data <= jdata_d;
      end
    end
  end

  flash_status_bits i_sr (
    .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy),
    .set_seq(set_seq), .set_prog(set_prog), .set_erase(set_erase),
    .clr_err(clr_err), .susp_erase(sus_er_q), .susp_prog(sus_pg_q),
    .sr(sr_w)
  );

  flash_read_path #(.MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) i_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sig_sel(rd_addr[0]),
    .mode(mode_q), .array_q(array_q), .sr(sr_w),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk
  import flash_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       job_start,
  input logic       susp_req,
  input logic       resume_req,
  input logic [7:0] sr,
  input logic [1:0] mode
);

  AST_CTRL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({job_start, susp_req, resume_req})); // R10

  AST_START_STATUS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |-> (mode == 2'(RM_STATUS))); // R3

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |=> !job_start); // R6

  AST_SUSP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> (sr[SR_ESUSP] ^ sr[SR_PSUSP])); // R10

  AST_RESUME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> (!sr[SR_ESUSP] && !sr[SR_PSUSP])); // R10

  AST_SEQ_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr[SR_SEQERR]) |-> !job_start); // R7

endmodule

bind flash_cmd_seq flash_cmd_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .job_start(job_start), .susp_req(susp_req),
  .resume_req(resume_req), .sr(sr_w), .mode(mode_q)
);

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int LIMIT = 20000;
  localparam logic [7:0] MFG = 8'h20;
  localparam logic [7:0] DEV = 8'hE5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] array_q;
  logic eng_busy = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
  logic rd_valid, job_start, susp_req, resume_req;
  logic [7:0] rd_data;
  logic [2:0] job_op;
  logic [AW-1:0] job_addr;
  logic [31:0] job_data;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign array_q = rd_addr[7:0] ^ 8'h5A;

  flash_cmd_seq #(.ADDR_W(AW), .MFG_ID(MFG), .DEV_ID(DEV)) i_flash_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .array_q(array_q),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_err(eng_err),
    .job_start(job_start), .job_op(job_op), .job_addr(job_addr), .job_data(job_data),
    .susp_req(susp_req), .resume_req(resume_req)
  );

  // ---------------- reference model ----------------
  int m_mode, m_step, m_qn;
  bit m_act, m_cur_er, m_sus_er, m_sus_pg, m_e5, m_e4, m_e3;
  logic [AW-1:0] m_qbase;
  logic [7:0] m_qb[4];
  bit e_start, e_sreq, e_rreq, e_rv;
  logic [2:0] e_op;
  logic [AW-1:0] e_addr;
  logic [31:0] e_data;
  logic [7:0] e_rd;

  function automatic logic [7:0] m_status();
    return {~eng_busy, m_sus_er, m_e5, m_e4, m_e3, m_sus_pg, 2'b00};
  endfunction

  task automatic m_launch(input int op, input logic [AW-1:0] a, input logic [31:0] d, input bit er);
    e_start = 1; e_op = 3'(op); e_addr = a; e_data = d;
    m_act = 1; m_cur_er = er; m_step = 0;
  endtask

  always @(posedge clk) begin
    e_start = 0; e_sreq = 0; e_rreq = 0;
    if (!rst_n) begin
      m_mode = 0; m_step = 0; m_qn = 0; m_act = 0; m_cur_er = 0;
      m_sus_er = 0; m_sus_pg = 0; m_e5 = 0; m_e4 = 0; m_e3 = 0; e_rv = 0;
    end else begin
      bit old_act, p4, p5;
      old_act = m_act; p4 = 0; p5 = 0;
      e_rv = rd_en;
      if (rd_en) e_rd = (m_mode == 1) ? m_status() :
                        (m_mode == 2) ? (rd_addr[0] ? DEV : MFG) : (rd_addr[7:0] ^ 8'h5A);
      if (eng_done) begin
        m_act = 0;
        if (eng_err) begin if (m_cur_er) p5 = 1; else p4 = 1; end
      end
      if (wr_en) begin
        if (m_step == 1) m_launch(1, wr_addr, {24'h0, wr_data}, 0);
        else if (m_step == 2) begin
          if ((m_qn == 0 && wr_addr[1:0] == 0) ||
              (m_qn > 0 && wr_addr[AW-1:2] == m_qbase[AW-1:2] && wr_addr[1:0] == 2'(m_qn))) begin
            if (m_qn == 0) m_qbase = wr_addr;
            m_qb[m_qn] = wr_data; m_qn++;
            if (m_qn == 4) m_launch(2, m_qbase, {m_qb[3], m_qb[2], m_qb[1], m_qb[0]}, 0);
          end else begin m_e3 = 1; m_e4 = 1; m_step = 0; m_mode = 1; end
        end else if (m_step == 3) begin
          if (wr_data == 8'h10) m_launch(3, wr_addr, 0, 1);
          else begin m_e3 = 1; m_e5 = 1; m_step = 0; m_mode = 1; end
        end else if (m_step >= 4) begin
          if (wr_data == 8'hD0) m_launch(m_step, wr_addr, 0, 1);
          else begin m_e3 = 1; m_e5 = 1; m_step = 0; m_mode = 1; end
        end else if (old_act) begin
          if (wr_data == 8'h70) m_mode = 1;
          else if (wr_data == 8'hB0 && !(m_sus_er || m_sus_pg)) begin
            e_sreq = 1; m_act = 0; m_sus_er = m_cur_er; m_sus_pg = !m_cur_er;
          end
        end else if (m_sus_er || m_sus_pg) begin
          if (wr_data == 8'hFF) m_mode = 0;
          else if (wr_data == 8'h70) m_mode = 1;
          else if (wr_data == 8'hD0) begin
            e_rreq = 1; m_act = 1; m_cur_er = m_sus_er; m_sus_er = 0; m_sus_pg = 0; m_mode = 1;
          end else if (m_sus_er && (wr_data == 8'h40 || wr_data == 8'h10)) begin m_step = 1; m_mode = 1; end
          else if (m_sus_er && wr_data == 8'h30) begin m_step = 2; m_qn = 0; m_mode = 1; end
        end else begin
          case (wr_data)
            8'hFF: m_mode = 0;
            8'h70: m_mode = 1;
            8'h90, 8'h98: m_mode = 2;
            8'h40, 8'h10: begin m_step = 1; m_mode = 1; end
            8'h30: begin m_step = 2; m_qn = 0; m_mode = 1; end
            8'h80: begin m_step = 3; m_mode = 1; end
            8'h20: begin m_step = 4; m_mode = 1; end
            8'h32: begin m_step = 5; m_mode = 1; end
            8'h50: begin m_e5 = 0; m_e4 = 0; m_e3 = 0; end
            default: ;
          endcase
        end
      end
      if (p4) m_e4 = 1;
      if (p5) m_e5 = 1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      total++;
      if (job_start !== e_start || (e_start && (job_op !== e_op || job_addr !== e_addr || job_data !== e_data))) begin
        bad++;
        $display("FAIL R3/R4/R6 model job: got start=%0b op=%0d addr=%h data=%h exp start=%0b op=%0d addr=%h data=%h",
                 job_start, job_op, job_addr, job_data, e_start, e_op, e_addr, e_data);
      end
      if (susp_req !== e_sreq || resume_req !== e_rreq) begin
        bad++;
        $display("FAIL R10 model pulses: got susp=%0b res=%0b exp susp=%0b res=%0b", susp_req, resume_req, e_sreq, e_rreq);
      end
      if (rd_valid !== e_rv || (e_rv && rd_data !== e_rd)) begin
        bad++;
        $display("FAIL R2/R9 model read: got v=%0b d=%h exp v=%0b d=%h", rd_valid, rd_data, e_rv, e_rd);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    rd_addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check(rd_valid === 1'b1 && rd_data === exp, req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic job_chk(input logic [2:0] op, input logic [AW-1:0] a, input logic [31:0] d, input string req);
    check(job_start === 1'b1, req, {31'h0, job_start}, 32'h1);
    check(job_op === op && job_addr === a, req, {9'h0, job_op, job_addr}, {9'h0, op, a});
    check(job_data === d, req, job_data, d);
  endtask

  task automatic finish_job(input bit err);
    eng_busy = 1'b0; eng_done = 1'b1; eng_err = err;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc >= LIMIT && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got cycle %0d expected end before %0d", cyc, LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(job_start === 1'b0 && susp_req === 1'b0 && resume_req === 1'b0, "R1 pulses", 0, 0);
    rd(20'h00012, 8'h48, "R1 array mode");
    wr(0, 8'h70);
    rd(0, 8'h80, "R1 status");

    // R2 modes
    wr(0, 8'h90);
    rd(20'h00100, MFG, "R2 sig mfg");
    rd(20'h00101, DEV, "R2 sig dev");
    rd(20'h00100, MFG, "R2 sig persists");
    wr(0, 8'hFF);
    rd(20'h000A5, 8'hFF, "R2 array");
    wr(0, 8'h98);
    rd(20'h00001, DEV, "R2 sig alt opcode");
    wr(0, 8'hFF);

    // R12 reserved opcodes
    wr(0, 8'h60); wr(0, 8'h00); wr(0, 8'hC0); wr(0, 8'h2F); wr(0, 8'h01);
    rd(20'h00033, 8'h69, "R12 mode kept");
    wr(0, 8'h70);
    rd(0, 8'h80, "R12 status kept");

    // R3 program, R9 busy/error, R8 clear
    wr(0, 8'hFF);
    wr(0, 8'h40);
    wr(20'h00345, 8'hA7);
    job_chk(3'd1, 20'h00345, 32'h0000_00A7, "R3 program");
    eng_busy = 1'b1;
    rd(0, 8'h00, "R9 busy status");
    finish_job(1'b1);
    rd(0, 8'h90, "R9 program error");
    wr(0, 8'h50);
    rd(0, 8'h80, "R8 clear");

    // R4 quad program
    wr(0, 8'h30);
    wr(20'h01000, 8'h11); wr(20'h01001, 8'h22); wr(20'h01002, 8'h33); wr(20'h01003, 8'h44);
    job_chk(3'd2, 20'h01000, 32'h4433_2211, "R4 quad");
    eng_busy = 1'b1; @(negedge clk); finish_job(1'b0);

    // R5 quad address violation
    wr(0, 8'h30);
    wr(20'h02000, 8'h01); wr(20'h02001, 8'h02); wr(20'h02003, 8'h03);
    check(job_start === 1'b0, "R5 no start", {31'h0, job_start}, 0);
    rd(0, 8'h98, "R5 error bits");
    wr(0, 8'h50);

    // R6 erases
    wr(0, 8'h20); wr(20'h30000, 8'hD0);
    job_chk(3'd4, 20'h30000, 32'h0, "R6 block");
    eng_busy = 1'b1; @(negedge clk); finish_job(1'b1);
    rd(0, 8'hA0, "R9 erase error");
    wr(0, 8'h50);
    wr(0, 8'h32); wr(20'h41234, 8'hD0);
    job_chk(3'd5, 20'h41234, 32'h0, "R6 sector");
    finish_job(1'b0);
    wr(0, 8'h80); wr(20'h00007, 8'h10);
    job_chk(3'd3, 20'h00007, 32'h0, "R6 chip");
    finish_job(1'b0);

    // R7 wrong confirm
    wr(0, 8'h20); wr(20'h50000, 8'hFF);
    check(job_start === 1'b0, "R7 no start", {31'h0, job_start}, 0);
    rd(0, 8'hA8, "R7 error bits");
    wr(0, 8'h50);
    rd(0, 8'h80, "R8 clear again");

    // R13 busy filtering, R10 erase suspend, R11 suspend filter
    wr(0, 8'h20); wr(20'h60000, 8'hD0);
    eng_busy = 1'b1;
    wr(0, 8'h90);
    rd(0, 8'h00, "R13 sig ignored while busy");
    wr(0, 8'hB0);
    check(susp_req === 1'b1, "R10 suspend pulse", {31'h0, susp_req}, 1);
    eng_busy = 1'b0;
    rd(0, 8'hC0, "R10 erase suspended");
    wr(0, 8'h90);
    rd(0, 8'hC0, "R11 sig ignored in suspend");
    wr(0, 8'hFF);
    rd(20'h00010, 8'h4A, "R11 array allowed");
    wr(0, 8'h20);
    rd(20'h00011, 8'h4B, "R11 erase ignored");
    wr(0, 8'h40); wr(20'h00055, 8'h01);
    job_chk(3'd1, 20'h00055, 32'h1, "R11 program in erase suspend");
    eng_busy = 1'b1; @(negedge clk); finish_job(1'b0);
    wr(0, 8'hD0);
    check(resume_req === 1'b1, "R10 resume pulse", {31'h0, resume_req}, 1);
    eng_busy = 1'b1;
    rd(0, 8'h00, "R10 suspend bit cleared");
    finish_job(1'b0);

    // R10 program suspend
    wr(0, 8'h40); wr(20'h00077, 8'h5C);
    job_chk(3'd1, 20'h00077, 32'h5C, "R3 program again");
    eng_busy = 1'b1; @(negedge clk);
    wr(0, 8'hB0);
    eng_busy = 1'b0;
    rd(0, 8'h84, "R10 program suspended");
    wr(0, 8'h40);
    wr(0, 8'h70);
    rd(0, 8'h84, "R11 program refused in program suspend");
    wr(0, 8'hD0);
    check(resume_req === 1'b1, "R10 resume program", {31'h0, resume_req}, 1);
    eng_busy = 1'b1; @(negedge clk); finish_job(1'b0);
    rd(0, 8'h80, "R9 ready after done");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule